// File: doc/BRIEF.md
# Fractional-N Pixel Clock Enable Divider

This block turns one of three source-clock tick streams into a divided, single-cycle enable pulse for pixel sampling logic. The division ratio is an integer part N plus a fraction num/den. A phase accumulator spreads the fraction over successive output periods: some periods last N ticks of the chosen source and others last N+1. Across many periods the average length is N + num/den.

A 2-bit select code picks the source stream, and code 0 shuts the output off. A separate enable bit also gates the output, and its registered state is returned for readback. Settings are only taken up at a period boundary, so a change made in the middle of a period never shortens that period. An integer part below 2 is raised to 2, and a status bit shows that this has happened. Each source is modelled as a tick (enable) input running in the block's own clock domain.

Top module: `frac_clk_div`

## Requirements
- R1: With 0 < num < den, period k (counting from 1 after enabling) lasts N+1 selected ticks when floor(k*num/den) > floor((k-1)*num/den), and N ticks otherwise.
- R2: When den is 0 or num is 0, every period lasts exactly N selected ticks.
- R3: When num >= den (both nonzero), every period lasts N+1 selected ticks.
- R4: An integer part of 0 or 1 is handled as 2. clamp_flag is 1 while the settings taken up at the last load had an integer part below 2, and 0 otherwise. It changes only when settings are loaded.
- R5: src_sel code 1 counts src_tick[0], code 2 counts src_tick[1], and code 3 counts src_tick[2]. Ticks on the inputs that are not selected have no effect.
- R6: While src_sel is 0, pix_en stays low.
- R7: While gate_en is low, pix_en stays low. gate_sts equals gate_en delayed by one clock.
- R8: Settings are sampled at the first selected tick after enabling and again at the final tick of every period. A change made in mid-period takes effect in the following period.
- R9: pix_en is high for exactly one clock, the clock after the final tick of a period, and is never high in two consecutive clocks.
- R10: Whenever the output is re-enabled (gate_en high and src_sel nonzero after either was off), the accumulator restarts at 0 and the first selected tick is tick 1 of period 1.
- R11: After reset, pix_en, clamp_flag and gate_sts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | One tick stream per source: bit 0 crystal, bit 1 fast PLL, bit 2 slower PLL |
| src_sel | input | 2 | Source code: 0 off, 1..3 select src_tick[code-1] |
| gate_en | input | 1 | Output enable bit |
| div_int | input | 8 | Integer part N (values below 2 are handled as 2) |
| frac_den | input | 6 | Fraction denominator |
| frac_num | input | 6 | Fraction numerator |
| pix_en | output | 1 | Divided single-cycle enable pulse |
| clamp_flag | output | 1 | Active settings had N below 2 |
| gate_sts | output | 1 | Registered readback of gate_en |

## Verification
A wrong accumulator value never changes the pulse shape. It appears only as a period that is one tick too long or too short, at the first period where the long/short pattern differs from the floor sequence. For that reason every period length is measured in selected ticks and compared with the value expected for that period. A wrong counter or a missed load shows up within one or two periods. A load of the settings at the wrong point shows up in the period right after a mid-period change. A wrong source mapping shifts the tick count almost at once, because unselected sources tick at random.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned INT_W  = 8;
  localparam int unsigned FRAC_W = 6;
  localparam int unsigned ACC_W  = FRAC_W + 1;
  localparam int unsigned LEN_W  = INT_W + 1;
  localparam int unsigned MIN_N  = 2;

  typedef struct packed {
    logic              long_p;
    logic [FRAC_W-1:0] acc;
  } phase_t;

  // integer part with the lower bound applied
  function automatic logic [INT_W-1:0] eff_int(input logic [INT_W-1:0] n);
    if (n < INT_W'(MIN_N)) return INT_W'(MIN_N);
    return n;
  endfunction

  // one accumulator step: decides whether the next period is long
  function automatic phase_t step_phase(input logic [FRAC_W-1:0] acc,
                                        input logic [FRAC_W-1:0] num,
                                        input logic [FRAC_W-1:0] den);
    phase_t           r;
    logic [ACC_W-1:0] s;
    s = {1'b0, acc} + {1'b0, num};
    if (den == '0 || num == '0) begin
      r.long_p = 1'b0;
      r.acc    = '0;
    end else if (num >= den) begin
      r.long_p = 1'b1;
      r.acc    = '0;
    end else if (s >= {1'b0, den}) begin
      r.long_p = 1'b1;
      r.acc    = FRAC_W'(s - {1'b0, den});
    end else begin
      r.long_p = 1'b0;
      r.acc    = s[FRAC_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/frac_src_pick.sv
module frac_src_pick #(
  parameter int unsigned NUM_SRC = 3,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = (src_sel == SEL_W'(i + 1)) && src_tick[i];
  end

  assign tick = |hit;
endmodule

// File: rtl/frac_phase.sv
module frac_phase
  import frac_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic              prime,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  output logic [LEN_W-1:0]  len,
  output logic              clamp_flag
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_base;
  phase_t            nxt;

  assign acc_base = prime ? '0 : acc_q;
  assign nxt      = step_phase(acc_base, frac_num, frac_den);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      len        <= LEN_W'(MIN_N);
      clamp_flag <= 1'b0;
    end else if (!run) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q      <= nxt.acc;
      len        <= {1'b0, eff_int(div_int)} + LEN_W'(nxt.long_p);
      clamp_flag <= (div_int < INT_W'(MIN_N));
    end
  end
endmodule

// File: rtl/frac_period_cnt.sv
module frac_period_cnt
  import frac_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             prime,
  output logic             load,
  output logic             pulse
);
  logic [LEN_W-1:0] cnt_q;
  logic             primed_q;
  logic             boundary;

  assign prime    = run && tick && !primed_q;
  assign boundary = run && tick && primed_q && (cnt_q + LEN_W'(1) == len);
  assign load     = prime || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      pulse    <= 1'b0;
    end else if (!run) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      pulse <= boundary;
      if (prime) begin
        primed_q <= 1'b1;
        cnt_q    <= LEN_W'(1);
      end else if (boundary) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               gate_en,
  input  logic [INT_W-1:0]   div_int,
  input  logic [FRAC_W-1:0]  frac_den,
  input  logic [FRAC_W-1:0]  frac_num,
  output logic               pix_en,
  output logic               clamp_flag,
  output logic               gate_sts
);
  logic             run_w;
  logic             tick_w;
  logic             prime_w;
  logic             load_w;
  logic [LEN_W-1:0] len_w;

  assign run_w = gate_en && (src_sel != '0);

  frac_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .src_tick (src_tick),
    .src_sel  (src_sel),
    .tick     (tick_w)
  );

  frac_period_cnt u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .tick  (tick_w),
    .len   (len_w),
    .prime (prime_w),
    .load  (load_w),
    .pulse (pix_en)
  );

  frac_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .load       (load_w),
    .prime      (prime_w),
    .div_int    (div_int),
    .frac_num   (frac_num),
    .frac_den   (frac_den),
    .len        (len_w),
    .clamp_flag (clamp_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_sts <= 1'b0;
    else        gate_sts <= gate_en;
  end
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic [SEL_W-1:0] src_sel,
  input logic             pix_en,
  input logic             tick_w,
  input logic             load_w,
  input logic             clamp_flag
);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  assert_pulse_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> $past(tick_w));

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !pix_en);

  assert_sel_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == '0) |=> !pix_en);

  assert_clamp_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clamp_flag) |-> $past(load_w));
endmodule

bind frac_clk_div frac_clk_div_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_tick = '0;
  logic [1:0] src_sel = '0;
  logic       gate_en = 1'b0;
  logic [7:0] div_int = 8'd4;
  logic [5:0] frac_den = '0;
  logic [5:0] frac_num = '0;
  logic       pix_en, clamp_flag, gate_sts;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  frac_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
    .gate_en(gate_en), .div_int(div_int), .frac_den(frac_den),
    .frac_num(frac_num), .pix_en(pix_en), .clamp_flag(clamp_flag),
    .gate_sts(gate_sts)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected length of period k, written from the floor sequence
  function automatic int exp_len(input int n, input int a, input int b, input int k);
    int ne = (n < 2) ? 2 : n;
    if (a == 0 || b == 0) return ne;
    if (b >= a) return ne + 1;
    return ((k * b) / a != ((k - 1) * b) / a) ? ne + 1 : ne;
  endfunction

  // measures period lengths in selected ticks; optional mid-period change of N
  task automatic measure(input int n, input int a, input int b, input int s,
                         input int periods, input string tag, input bit dense,
                         input int chg_at, input int n2);
    int cnt = 0;
    int k = 0;
    int guard = 0;
    bit last = 0;
    gate_en = 1'b0;
    @(negedge clk);
    div_int = 8'(n); frac_den = 6'(a); frac_num = 6'(b); src_sel = 2'(s);
    @(negedge clk);
    gate_en = 1'b1;
    while (k < periods && guard < 20000) begin
      bit tk;
      src_tick = dense ? 3'b111 : 3'($urandom_range(0, 7));
      tk = src_tick[s-1];
      @(negedge clk);
      guard++;
      if (tk) cnt++;
      if (chg_at > 0 && k == 0 && cnt == chg_at) div_int = 8'(n2);
      if (pix_en) begin
        int e;
        e = (chg_at > 0 && k > 0) ? exp_len(n2, a, b, k + 1) : exp_len(n, a, b, k + 1);
        check(cnt == e, (k == 0) ? {tag, "/R10"} : tag, cnt, e);
        check(!last, "R9", int'(last), 0);
        k++;
        cnt = 0;
      end
      last = pix_en;
    end
    check(k == periods, {tag, " periods"}, k, periods);
    gate_en = 1'b0;
    src_tick = '0;
    @(negedge clk);
  endtask

  // no pulse may appear for a span of random ticks
  task automatic expect_silent(input string req, input int span, input bit only_unsel, input int s);
    int pulses = 0;
    for (int i = 0; i < span; i++) begin
      src_tick = 3'($urandom_range(0, 7));
      if (only_unsel) src_tick[s-1] = 1'b0;
      @(negedge clk);
      if (pix_en) pulses++;
    end
    check(pulses == 0, req, pulses, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(pix_en == 1'b0, "R11 pix_en", int'(pix_en), 0);
    check(clamp_flag == 1'b0, "R11 clamp_flag", int'(clamp_flag), 0);
    check(gate_sts == 1'b0, "R11 gate_sts", int'(gate_sts), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 readback timing
    gate_en = 1'b1;
    check(gate_sts == 1'b0, "R7 gate_sts before edge", int'(gate_sts), 0);
    @(negedge clk);
    check(gate_sts == 1'b1, "R7 gate_sts", int'(gate_sts), 1);
    gate_en = 1'b0;
    @(negedge clk);
    check(gate_sts == 1'b0, "R7 gate_sts low", int'(gate_sts), 0);

    // directed corner cases
    measure(5, 0, 3, 1, 6, "R2", 1'b1, 0, 0);
    measure(7, 9, 0, 2, 6, "R2", 1'b0, 0, 0);
    measure(3, 4, 9, 3, 6, "R3", 1'b0, 0, 0);
    measure(4, 5, 2, 1, 15, "R1", 1'b0, 0, 0);
    measure(2, 63, 62, 2, 20, "R1", 1'b1, 0, 0);
    measure(255, 3, 1, 3, 3, "R1", 1'b1, 0, 0);
    measure(1, 0, 0, 1, 5, "R4", 1'b0, 0, 0);
    check(clamp_flag == 1'b1, "R4 flag set", int'(clamp_flag), 1);
    measure(0, 0, 0, 2, 5, "R4", 1'b1, 0, 0);
    measure(3, 0, 0, 2, 3, "R4", 1'b1, 0, 0);
    check(clamp_flag == 1'b0, "R4 flag clear", int'(clamp_flag), 0);
    measure(5, 0, 0, 1, 4, "R8", 1'b1, 2, 9);

    // R6 and R7 silence, R5 unselected sources
    div_int = 8'd2; frac_den = '0; frac_num = '0;
    src_sel = 2'd0; gate_en = 1'b1;
    expect_silent("R6", 200, 1'b0, 1);
    src_sel = 2'd1; gate_en = 1'b0;
    expect_silent("R7", 200, 1'b0, 1);
    src_sel = 2'd2; gate_en = 1'b1;
    expect_silent("R5", 200, 1'b1, 2);
    gate_en = 1'b0;
    @(negedge clk);

    // random configurations over all three sources
    for (int i = 0; i < 12; i++) begin
      int n = $urandom_range(2, 20);
      int a = $urandom_range(0, 63);
      int b = $urandom_range(0, 63);
      int s = $urandom_range(1, 3);
      measure(n, a, b, s, 12, (b < a && b != 0) ? "R1/R5" : "R2/R3/R5", 1'b0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule